// File: doc/BRIEF.md
# Eight-Bit Memory-Mapped General-Purpose I/O Port

The block is an eight-pin bidirectional I/O port. Software reaches it through a simple peripheral register bus with a 16-bit address, a write strobe and a read strobe. Four registers are decoded:

- a direction register, which can only be written;
- an output latch;
- a pull-up enable mask;
- a read-only view of the pin state.

Per pin, the block drives an output enable, an output value and a pull-up enable. It samples the eight input pins through a two-stage synchronizer.

An operating-mode input can hand the pins over to an external data bus. In modes 4, 5 and 6 the port releases all of its output enables and pull-ups and ignores the direction setting. In every other mode, each direction bit selects output (1) or input (0) for its pin.

The two reset inputs behave differently, and so do the two standby inputs:

- Power-on reset clears everything.
- Manual reset clears the output latch and the pull-up mask but keeps the direction register.
- Hardware standby holds the direction register at zero.
- Software standby freezes all register contents.

Top module: `gpio_port8`

## Requirements
- R1: Registers are decoded on all 16 address bits: direction at 0xFE3C, output latch at 0xFF0C, pin state at 0xFFBC, pull-up mask at 0xFE43. A read of any other address returns 0x00, and a write to any other address changes nothing.
- R2: A write changes the addressed register at the clock edge that samples wrEn high. The output latch and the pull-up mask read back the value written.
- R3: rdData is registered. It shows the addressed value from the edge that samples rdEn high, and it holds its value while rdEn is low.
- R4: A read of the direction register address returns 0x00.
- R5: While porRstN is low, the direction register, the output latch, the pull-up mask, rdData and the synchronizer are all 0x00.
- R6: A clock edge with manRstN low clears the output latch and the pull-up mask, keeps the direction register, and ignores writes.
- R7: While hwStby is high, the direction register is held at 0x00 and writes are ignored.
- R8: While swStby is high, writes are ignored and every register keeps its value.
- R9: With mode 4, 5 or 6, pinOe and pullEn are 0x00 whatever the direction and pull-up registers hold.
- R10: In any other mode, pinOe equals the direction register. pinOut always equals the output latch.
- R11: A pin-state read returns the output-latch bit for each pin whose output enable is 1, and the synchronized input bit for every other pin. A pin change driven before edge A is seen by a read sampled at edge A+2, but not by reads sampled at edges A or A+1.
- R12: pullEn equals the pull-up mask ANDed with the inverted direction register, outside modes 4 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| manRstN | input | 1 | Manual reset, synchronous, active low |
| hwStby | input | 1 | Hardware standby |
| swStby | input | 1 | Software standby |
| mode | input | 3 | Operating mode; values 4 to 6 hand the pins to the external bus |
| addr | input | 16 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| pinIn | input | 8 | Pin levels from the pads |
| pinOe | output | 8 | Per-pin output enable |
| pinOut | output | 8 | Per-pin output value |
| pullEn | output | 8 | Per-pin pull-up enable |

## Verification
The pin-state read is exercised with mixed direction masks, so that a swapped selection between latch bits and input bits shows up. It is also run in bus mode, where every pin must read as an input. Back-to-back reads right after a pin change separate a one-stage synchronizer from a two-stage one.

Writes are issued under manual reset, under each standby input and to an unmapped address. Each case tells apart which registers a given condition may touch.

Mode sweeps across 3, 4, 6 and 7 show whether the direction and pull-up registers are really masked only in the bus modes.

// File: rtl/gpio_port8_pkg.sv
package gpio_port8_pkg;

  typedef struct packed {
    logic wrDir;
    logic wrLatch;
    logic wrPull;
    logic rdAny;
    logic rdLatch;
    logic rdPin;
    logic rdPull;
  } regStrobe_t;

endpackage

// File: rtl/gpio_port8_ctrl.sv
module gpio_port8_ctrl
  import gpio_port8_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR   = 16'hFE3C,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'hFF0C,
  parameter logic [ADDR_W-1:0] PIN_ADDR   = 16'hFFBC,
  parameter logic [ADDR_W-1:0] PULL_ADDR  = 16'hFE43
) (
  input  logic              manRstN,
  input  logic              hwStby,
  input  logic              swStby,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output regStrobe_t        strobe
);

  logic hitDir, hitLatch, hitPin, hitPull, wrOk;

  always_comb begin
    hitDir   = (addr == DIR_ADDR);
    hitLatch = (addr == LATCH_ADDR);
    hitPin   = (addr == PIN_ADDR);
    hitPull  = (addr == PULL_ADDR);
    // writes are blocked by manual reset and by either standby
    wrOk     = wrEn && manRstN && !hwStby && !swStby;

    strobe.wrDir   = wrOk && hitDir;
    strobe.wrLatch = wrOk && hitLatch;
    strobe.wrPull  = wrOk && hitPull;
    strobe.rdAny   = rdEn;
    strobe.rdLatch = rdEn && hitLatch;
    strobe.rdPin   = rdEn && hitPin;
    strobe.rdPull  = rdEn && hitPull;
  end

  // R1: at most one register selected per access
  always_comb begin
    p_one_select_r1: assert ($onehot0({strobe.rdLatch, strobe.rdPin, strobe.rdPull}))
      else $error("p_one_select_r1");
  end

endmodule

// File: rtl/gpio_port8_dp.sv
module gpio_port8_dp
  import gpio_port8_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRstN,
  input  logic              hwStby,
  input  logic              swStby,
  input  logic [MODE_W-1:0] mode,
  input  regStrobe_t        strobe,
  input  logic [PORT_W-1:0] wrData,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] rdData,
  output logic [PORT_W-1:0] pinOe,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pullEn
);

  logic [PORT_W-1:0] dirReg, latchReg, pullReg, pinState, rdNext;
  logic [PORT_W-1:0] syncQ [SYNC_STAGES];
  logic busMode;

  assign busMode = (mode >= MODE_W'(4)) && (mode <= MODE_W'(6));

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)         dirReg <= '0;
    else if (hwStby)      dirReg <= '0;
    else if (strobe.wrDir) dirReg <= wrData;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      latchReg <= '0;
      pullReg  <= '0;
    end else if (!manRstN) begin
      latchReg <= '0;
      pullReg  <= '0;
    end else begin
      if (strobe.wrLatch) latchReg <= wrData;
      if (strobe.wrPull)  pullReg  <= wrData;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= pinIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    pinOe    = busMode ? '0 : dirReg;
    pinOut   = latchReg;
    pullEn   = busMode ? '0 : (pullReg & ~dirReg);
    pinState = (latchReg & pinOe) | (syncQ[SYNC_STAGES-1] & ~pinOe);
    rdNext   = '0;
    if (strobe.rdLatch)     rdNext = latchReg;
    else if (strobe.rdPin)  rdNext = pinState;
    else if (strobe.rdPull) rdNext = pullReg;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)          rdData <= '0;
    else if (strobe.rdAny) rdData <= rdNext;
  end

  p_hwstby_clear_r7: assert property (@(posedge clk) disable iff (!porRstN)
    hwStby |=> (dirReg == '0)) else $error("p_hwstby_clear_r7");

  p_dir_keep_r6: assert property (@(posedge clk) disable iff (!porRstN)
    ((!manRstN || swStby) && !hwStby) |=> $stable(dirReg)) else $error("p_dir_keep_r6");

  p_latch_keep_r8: assert property (@(posedge clk) disable iff (!porRstN)
    (swStby && manRstN) |=> ($stable(latchReg) && $stable(pullReg))) else $error("p_latch_keep_r8");

  p_bus_release_r9: assert property (@(posedge clk) disable iff (!porRstN)
    busMode |-> (pinOe == '0 && pullEn == '0)) else $error("p_bus_release_r9");

  p_pull_inputs_r12: assert property (@(posedge clk) disable iff (!porRstN)
    (pullEn & pinOe) == '0) else $error("p_pull_inputs_r12");

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!porRstN)
    !strobe.rdAny |=> $stable(rdData)) else $error("p_rd_hold_r3");

  p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!porRstN)
    (strobe.rdAny && !strobe.rdLatch && !strobe.rdPin && !strobe.rdPull) |=> (rdData == '0))
    else $error("p_unmapped_zero_r4");

endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
  import gpio_port8_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter int MODE_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRstN,
  input  logic              hwStby,
  input  logic              swStby,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [PORT_W-1:0] rdData,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] pinOe,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pullEn
);

  regStrobe_t strobe;

  gpio_port8_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .manRstN(manRstN), .hwStby(hwStby), .swStby(swStby),
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .strobe(strobe)
  );

  gpio_port8_dp #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES), .MODE_W(MODE_W)) dp_i (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .hwStby(hwStby), .swStby(swStby),
    .mode(mode), .strobe(strobe), .wrData(wrData), .pinIn(pinIn),
    .rdData(rdData), .pinOe(pinOe), .pinOut(pinOut), .pullEn(pullEn)
  );

endmodule

// File: tb/gpio_port8_tb_top.sv
module gpio_port8_tb_top;

  localparam logic [15:0] A_DIR = 16'hFE3C, A_LAT = 16'hFF0C,
                          A_PIN = 16'hFFBC, A_PUL = 16'hFE43;

  logic clk = 1'b0;
  logic porRstN = 1'b0, manRstN = 1'b1, hwStby = 1'b0, swStby = 1'b0;
  logic [2:0] mode = 3'd7;
  logic [15:0] addr = '0;
  logic [7:0] wrData = '0, pinIn = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] rdData, pinOe, pinOut, pullEn;
  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  gpio_port8 dut_i (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .hwStby(hwStby), .swStby(swStby),
    .mode(mode), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData), .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut), .pullEn(pullEn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(posedge clk); @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic t_reset();
    check("R5 rdData", rdData, 8'h00);
    check("R5 pinOe", pinOe, 8'h00);
    check("R5 pinOut", pinOut, 8'h00);
    check("R5 pullEn", pullEn, 8'h00);
  endtask

  task automatic t_rw();
    logic [7:0] v;
    wr(A_LAT, 8'h5A); check("R2 pinOut after write", pinOut, 8'h5A);
    rd(A_LAT, v); check("R2 latch readback", v, 8'h5A);
    wr(A_PUL, 8'hC3); rd(A_PUL, v); check("R2 pull readback", v, 8'hC3);
    repeat (3) @(negedge clk);
    check("R3 rdData held", rdData, 8'hC3);
    wr(A_DIR, 8'hF0); rd(A_DIR, v); check("R4 dir reads zero", v, 8'h00);
    check("R10 pinOe=dir", pinOe, 8'hF0);
    check("R12 pullEn", pullEn, 8'h03);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(16'hFE3D, 8'hFF); wr(16'h0C0C, 8'hFF);
    rd(A_LAT, v); check("R1 latch unchanged", v, 8'h5A);
    rd(A_PUL, v); check("R1 pull unchanged", v, 8'hC3);
    check("R1 dir unchanged", pinOe, 8'hF0);
    rd(16'h1234, v); check("R1 unmapped read", v, 8'h00);
  endtask

  task automatic t_pin();
    logic [7:0] v;
    wr(A_LAT, 8'hA5); wr(A_DIR, 8'h0F);
    pinIn = 8'h3C; repeat (3) @(negedge clk);
    rd(A_PIN, v); check("R11 mixed pin read", v, 8'h35);
    // latency: change then three back-to-back reads
    @(negedge clk); pinIn = 8'hC0; addr = A_PIN; rdEn = 1'b1;
    @(posedge clk); @(negedge clk); check("R11 edge A old", rdData, 8'h35);
    @(posedge clk); @(negedge clk); check("R11 edge A+1 old", rdData, 8'h35);
    @(posedge clk); @(negedge clk); check("R11 edge A+2 new", rdData, 8'hC5);
    rdEn = 1'b0;
  endtask

  task automatic t_mode();
    logic [7:0] v;
    wr(A_PUL, 8'hFF); wr(A_DIR, 8'h0F);
    mode = 3'd4; @(negedge clk);
    check("R9 mode4 pinOe", pinOe, 8'h00); check("R9 mode4 pullEn", pullEn, 8'h00);
    rd(A_PIN, v); check("R11 bus mode all inputs", v, 8'hC0);
    mode = 3'd6; @(negedge clk);
    check("R9 mode6 pinOe", pinOe, 8'h00); check("R9 mode6 pullEn", pullEn, 8'h00);
    check("R10 pinOut in bus mode", pinOut, 8'hA5);
    mode = 3'd3; @(negedge clk);
    check("R10 mode3 pinOe", pinOe, 8'h0F); check("R12 mode3 pullEn", pullEn, 8'hF0);
    mode = 3'd7; @(negedge clk);
    check("R12 mode7 pullEn", pullEn, 8'hF0);
  endtask

  task automatic t_manrst();
    logic [7:0] v;
    @(negedge clk); manRstN = 1'b0; addr = A_DIR; wrData = 8'h55; wrEn = 1'b1;
    @(posedge clk); @(negedge clk); manRstN = 1'b1; wrEn = 1'b0;
    check("R6 dir kept", pinOe, 8'h0F);
    check("R6 latch cleared", pinOut, 8'h00);
    rd(A_PUL, v); check("R6 pull cleared", v, 8'h00);
  endtask

  task automatic t_stby();
    logic [7:0] v;
    wr(A_LAT, 8'h77); wr(A_PUL, 8'h11);
    @(negedge clk); swStby = 1'b1;
    wr(A_LAT, 8'h00); wr(A_DIR, 8'hFF); wr(A_PUL, 8'hEE);
    @(negedge clk); swStby = 1'b0;
    check("R8 latch kept", pinOut, 8'h77);
    check("R8 dir kept", pinOe, 8'h0F);
    rd(A_PUL, v); check("R8 pull kept", v, 8'h11);
    @(negedge clk); hwStby = 1'b1;
    @(negedge clk); check("R7 dir cleared", pinOe, 8'h00);
    wr(A_DIR, 8'hFF); check("R7 write ignored", pinOe, 8'h00);
    @(negedge clk); hwStby = 1'b0; @(negedge clk);
    check("R7 dir stays zero", pinOe, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    porRstN = 1'b1;
    t_rw(); t_unmapped(); t_pin(); t_mode(); t_manrst(); t_stby();
    @(negedge clk); porRstN = 1'b0; @(negedge clk);
    check("R5 pinOut after por", pinOut, 8'h00);
    check("R5 pullEn after por", pullEn, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule